// File: doc/BRIEF.md
# Dual-Mode Serial Peripheral Port

This block is a byte-wide SPI port. A control bit chooses master or slave operation. In master mode the port generates SCK from the system clock. In slave mode it follows an SCK supplied by another device, and it is active only while the select input is low.

The CPU uses a small parallel register window with a control register, a status register and a data register. A write to the data register loads the byte to send. A read of the data register returns the byte last received. Both modes use one 8-bit shift register. Data moves MSB first with mode-0 timing: SCK idles low, the line is sampled on the rising edge and changed on the falling edge.

Behaviour is held in a four-state machine:

- `ST_IDLE`: no transfer.
- `ST_MLOW`: master, SCK low half.
- `ST_MHIGH`: master, SCK high half.
- `ST_SLAVE`: selected slave.

Transitions:

- `ST_IDLE`→`ST_MLOW` on a data write while the port is enabled as master.
- `ST_IDLE`→`ST_SLAVE` when the port is enabled as slave and the synchronised select is low.
- `ST_MLOW`→`ST_MHIGH` on a divider tick.
- `ST_MHIGH`→`ST_MLOW` on a tick before the last bit.
- `ST_MHIGH`→`ST_IDLE` on the tick ending the eighth bit.
- `ST_SLAVE`→`ST_IDLE` when select rises or master mode is chosen.
- Any state → `ST_IDLE` when the enable bit is cleared.

Top module: `spi_port`

## Requirements
- R1: Register addresses are 0 for control, 1 for status and 2 for data. Control bit 0 enables the port, bit 1 selects master mode and bits 3:2 select the rate. The control register reads back as written, with the upper bits zero.
- R2: Pin directions depend on the mode:
  - Enabled master: `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0.
  - Enabled slave: `sck_oe` and `mosi_oe` are 0.
  - Disabled: all three enables are 0.
  - `mosi_oe` and `miso_oe` are never 1 together.
- R3: In master mode, a data write while idle produces exactly 8 SCK high pulses. SCK rests low when idle. The written byte appears on `mosi_o` MSB first, changing after falling edges.
- R4: In master mode, each SCK high and low phase lasts half the divide ratio in system clocks. The rate codes 00, 01, 10 and 11 give ratios 4, 8, 32 and 64.
- R5: In master mode, `miso_i` is sampled at each SCK rising edge. The 8 sampled bits, MSB first, are read from the data register after the transfer.
- R6: In master mode, `ss_n_i` has no effect on the transfer or on the pin directions.
- R7: In slave mode, the port responds only while `ss_n_i` is low:
  - With `ss_n_i` high, `miso_oe` is 0 and SCK edges are ignored.
  - Raising `ss_n_i` in the middle of a byte discards the partial byte, so the next selection starts at bit 0.
- R8: In slave mode, a byte written while idle is shifted out on `miso_o` MSB first during the next selection. The byte received on `mosi_i` is read from the data register.
- R9: Completing a byte in either mode sets status bit 7 and raises `irq`.
- R10: The completion flag clears only when the status register is read while the flag is set and the data register is read afterwards. A data read without that earlier status read leaves the flag set.
- R11: Status bit 6 reads 1 while a master transfer is in progress. A data write during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Transfer-complete request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master-out line, driven in master mode |
| mosi_oe | output | 1 | Master-out output enable |
| mosi_i | input | 1 | Master-out line, sampled in slave mode |
| miso_o | output | 1 | Master-in line, driven in slave mode |
| miso_oe | output | 1 | Master-in output enable |
| miso_i | input | 1 | Master-in line, sampled in master mode |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The following properties are checked on every cycle:

- The output enables are mutually exclusive.
- SCK rests low in the idle state.
- Each master SCK high phase lasts half the selected ratio.
- A deselected slave leaves the slave state.
- A completed byte raises the request.
- The request falls only on a data-register read.

The following can be shown only by the bench's scenarios:

- Byte contents in both directions and MSB-first order.
- The count of eight pulses and the preload of the slave reply.
- Discarding a byte aborted by a mid-byte deselect.
- Ignoring select in master mode.
- The two-step clearing sequence.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MLOW  = 2'd1,
        ST_MHIGH = 2'd2,
        ST_SLAVE = 2'd3
    } spi_state_e;

    // Control register image: [3:2] rate, [1] master, [0] enable
    typedef struct packed {
        logic [1:0] rate;
        logic       master;
        logic       enable;
    } spi_ctrl_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // half phase = ratio/2 : 2, 4, 16, 32 system clocks
    always_comb begin
        unique case (rate)
            2'd0: half_m1 = CNT_W'(1);
            2'd1: half_m1 = CNT_W'(3);
            2'd2: half_m1 = CNT_W'(15);
            default: half_m1 = CNT_W'(31);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i,
    input  logic              ss_n_i
);
    localparam int                BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);

    spi_state_e        state_q, state_d;
    spi_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] shreg_q, rxbuf_q;
    logic [BIT_W-1:0]  bit_q;
    logic              in_bit_q, flag_q, arm_q, sck_d_q;
    logic              sck_s, mosi_s, ss_s, sck_rise, sck_fall;
    logic              tick, samp_ev, shift_ev, done_ev, load_ev, abort_ev;
    logic              wr_ctrl, wr_data, rd_stat, rd_data, busy;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, mosi_i, ss_n_i}),
        .q     ({sck_s, mosi_s, ss_s})
    );

    spi_clkdiv #(.CNT_W(DIV_CNT_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q == ST_MLOW) || (state_q == ST_MHIGH)),
        .rate  (ctrl_q.rate),
        .tick  (tick)
    );

    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_data  = wr_en && (addr == REG_DATA);
    assign rd_stat  = rd_en && (addr == REG_STAT);
    assign rd_data  = rd_en && (addr == REG_DATA);
    assign sck_rise = sck_s && !sck_d_q;
    assign sck_fall = !sck_s && sck_d_q;
    assign busy     = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_q.enable && ctrl_q.master && wr_data)
                    state_d = ST_MLOW;
                else if (ctrl_q.enable && !ctrl_q.master && !ss_s)
                    state_d = ST_SLAVE;
            end
            ST_MLOW:  if (tick) state_d = ST_MHIGH;
            ST_MHIGH: if (tick) state_d = (bit_q == LAST_BIT) ? ST_IDLE : ST_MLOW;
            ST_SLAVE: if (ss_s || ctrl_q.master) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!ctrl_q.enable) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift events
    assign samp_ev  = ((state_q == ST_MLOW)  && tick) || ((state_q == ST_SLAVE) && sck_rise);
    assign shift_ev = ((state_q == ST_MHIGH) && tick) || ((state_q == ST_SLAVE) && sck_fall);
    assign done_ev  = shift_ev && (bit_q == LAST_BIT);
    assign load_ev  = wr_data && (state_q == ST_IDLE);
    assign abort_ev = busy && (state_d == ST_IDLE) && !done_ev;

    // Datapath and CPU-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            shreg_q  <= '0;
            rxbuf_q  <= '0;
            bit_q    <= '0;
            in_bit_q <= 1'b0;
            flag_q   <= 1'b0;
            arm_q    <= 1'b0;
            sck_d_q  <= 1'b0;
        end else begin
            sck_d_q <= sck_s;
            if (wr_ctrl) ctrl_q <= spi_ctrl_t'(wdata[3:0]);
            if (load_ev) begin
                shreg_q <= wdata;
                bit_q   <= '0;
            end
            if (samp_ev) in_bit_q <= (state_q == ST_SLAVE) ? mosi_s : miso_i;
            if (shift_ev) begin
                shreg_q <= {shreg_q[DATA_W-2:0], in_bit_q};
                bit_q   <= bit_q + 1'b1;
            end
            if (abort_ev) bit_q <= '0;
            if (done_ev) begin
                rxbuf_q <= {shreg_q[DATA_W-2:0], in_bit_q};
                flag_q  <= 1'b1;
                arm_q   <= 1'b0;
            end else begin
                if (rd_stat && flag_q) arm_q <= 1'b1;
                if (rd_data && arm_q) begin
                    flag_q <= 1'b0;
                    arm_q  <= 1'b0;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sck_o   = (state_q == ST_MHIGH);
        sck_oe  = ctrl_q.enable && ctrl_q.master;
        mosi_oe = ctrl_q.enable && ctrl_q.master;
        mosi_o  = shreg_q[DATA_W-1];
        miso_o  = shreg_q[DATA_W-1];
        miso_oe = ctrl_q.enable && !ctrl_q.master && !ss_s;
        irq     = flag_q;
        unique case (addr)
            REG_CTRL: rdata = DATA_W'(ctrl_q);
            REG_STAT: rdata = {flag_q, busy, {(DATA_W-2){1'b0}}};
            REG_DATA: rdata = rxbuf_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       irq,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input spi_state_e state_q,
    input spi_ctrl_t  ctrl_q,
    input logic       ss_s,
    input logic       done_ev
);
    logic [5:0] hi_len;
    logic [5:0] exp_half;

    always_comb begin
        unique case (ctrl_q.rate)
            2'd0: exp_half = 6'd2;
            2'd1: exp_half = 6'd4;
            2'd2: exp_half = 6'd16;
            default: exp_half = 6'd32;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_len <= '0;
        else if (sck_o) hi_len <= hi_len + 1'b1;
        else            hi_len <= '0;
    end

    p_dir_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe));

    p_sck_in_slave_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLAVE) |-> !sck_oe);

    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sck_o);

    p_hi_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> (hi_len == exp_half));

    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && !ctrl_q.master) |=> (state_q != ST_SLAVE));

    p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_ev |=> irq);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == REG_DATA)) |=> irq);
endmodule

bind spi_port spi_port_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .irq     (irq),
    .sck_o   (sck_o),
    .sck_oe  (sck_oe),
    .mosi_oe (mosi_oe),
    .miso_oe (miso_oe),
    .state_q (state_q),
    .ctrl_q  (ctrl_q),
    .ss_s    (ss_s),
    .done_ev (done_ev)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic       miso_i;

    int n_chk = 0, n_fail = 0;
    int n_items = 0, mon_done = 0;
    bit mon_on = 1'b1;

    logic [7:0] bslv_tx = 8'h00;
    logic [7:0] cap_m = 8'h00;
    logic [7:0] cap_s = 8'h00;
    int         pulses = 0;

    typedef struct {
        bit         slv;
        logic [7:0] rx;
        logic [7:0] line;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
        .ss_n_i(ss_n_i)
    );

    // Bench-side slave answering the master port (mode 0)
    assign miso_i = bslv_tx[7];
    always @(negedge sck_o) bslv_tx = {bslv_tx[6:0], 1'b0};
    always @(posedge sck_o) begin
        cap_m  = {cap_m[6:0], mosi_o};
        pulses = pulses + 1;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Driver: master transfer
    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] slave_byte, input string tag);
        item_t it;
        bslv_tx = slave_byte;
        cap_m   = 8'h00;
        pulses  = 0;
        it.slv = 1'b0; it.rx = slave_byte; it.line = tx; it.tag = tag;
        sb_q.push_back(it);
        n_items++;
        bus_write(2'd2, tx);
    endtask

    // Bench acting as master towards the slave port
    task automatic s_drive(input logic [7:0] mbyte, input int nbits);
        cap_s = 8'h00;
        @(negedge clk); ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi_i = mbyte[7-i];
            repeat (8) @(negedge clk);
            sck_i = 1'b1;
            cap_s = {cap_s[6:0], miso_o};
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: pops expected items on each completion
    initial begin
        logic [7:0] st, d;
        item_t it;
        forever begin
            @(posedge irq);
            if (mon_on) begin
                if (sb_q.size() == 0) begin
                    check_eq("R9", "unexpected completion", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    bus_read(2'd1, st);
                    check_eq("R9", {it.tag, " status flag"}, int'(st[7]), 1);
                    bus_read(2'd2, d);
                    check_eq(it.slv ? "R8" : "R5", {it.tag, " received byte"}, int'(d), int'(it.rx));
                    check_eq(it.slv ? "R8" : "R3", {it.tag, " byte on line"},
                             it.slv ? int'(cap_s) : int'(cap_m), int'(it.line));
                    if (!it.slv) check_eq("R3", {it.tag, " sck pulses"}, pulses, 8);
                    check_eq("R10", {it.tag, " irq after clear"}, int'(irq), 0);
                end
                mon_done++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state
        bus_read(2'd0, v); check_eq("R1", "ctrl after reset", int'(v), 0);
        bus_read(2'd1, v); check_eq("R9", "status after reset", int'(v), 0);
        check_eq("R2", "enables after reset", int'({sck_oe, mosi_oe, miso_oe}), 0);

        // R1 readback while disabled
        bus_write(2'd0, 8'h0E);
        bus_read(2'd0, v); check_eq("R1", "ctrl readback", int'(v), 8'h0E);
        check_eq("R2", "disabled enables", int'({sck_oe, mosi_oe, miso_oe}), 0);

        // Master, ratio 4
        bus_write(2'd0, 8'h03);
        check_eq("R2", "master enables", int'({sck_oe, mosi_oe, miso_oe}), 3'b110);
        check_eq("R3", "sck idle", int'(sck_o), 0);
        m_xfer(8'hA5, 8'h3C, "m1"); wait (mon_done == n_items);
        m_xfer(8'hFF, 8'h00, "m2"); wait (mon_done == n_items);
        m_xfer(8'h81, 8'h7E, "m3"); wait (mon_done == n_items);

        // R4: high/low phase lengths for each rate
        for (int r = 0; r < 4; r++) begin
            int half;
            half = (r == 0) ? 2 : (r == 1) ? 4 : (r == 2) ? 16 : 32;
            bus_write(2'd0, 8'(r << 2) | 8'h03);
            m_xfer(8'h5A ^ 8'(r), 8'hC3 ^ 8'(r), "rate");
            @(posedge sck_o);
            n = 0;
            @(negedge clk);
            while (sck_o) begin n++; @(negedge clk); end
            check_eq("R4", "high phase", n, half);
            n = 0;
            while (!sck_o) begin n++; @(negedge clk); end
            check_eq("R4", "low phase", n, half);
            wait (mon_done == n_items);
        end

        // R11: busy during transfer, write ignored (ctrl still rate 11)
        m_xfer(8'h96, 8'h69, "busy");
        repeat (10) @(negedge clk);
        bus_read(2'd1, v); check_eq("R11", "busy bit", int'(v[7:6]), 2'b01);
        bus_write(2'd2, 8'h00);
        wait (mon_done == n_items);

        // R6: select ignored in master mode
        bus_write(2'd0, 8'h03);
        ss_n_i = 1'b0;
        m_xfer(8'h12, 8'hED, "ss_low"); wait (mon_done == n_items);
        check_eq("R6", "enables with ss low", int'({sck_oe, mosi_oe, miso_oe}), 3'b110);
        ss_n_i = 1'b1;
        m_xfer(8'h34, 8'hCB, "ss_high"); wait (mon_done == n_items);
        check_eq("R6", "enables with ss high", int'({sck_oe, mosi_oe, miso_oe}), 3'b110);

        // R10: clearing sequence
        mon_on = 1'b0;
        bslv_tx = 8'h44;
        bus_write(2'd2, 8'h22);
        wait (irq == 1'b1);
        bus_read(2'd2, v); check_eq("R5", "r10 data", int'(v), 8'h44);
        check_eq("R10", "data read alone keeps flag", int'(irq), 1);
        bus_read(2'd1, v); check_eq("R10", "status read keeps flag", int'(irq), 1);
        bus_read(2'd2, v); check_eq("R10", "status then data clears", int'(irq), 0);
        mon_on = 1'b1;

        // Slave mode
        bus_write(2'd0, 8'h01);
        repeat (4) @(negedge clk);
        check_eq("R7", "slave deselected enables", int'({sck_oe, mosi_oe, miso_oe}), 0);
        // SCK pulses while deselected are ignored
        for (int i = 0; i < 8; i++) begin
            repeat (6) @(negedge clk); sck_i = 1'b1;
            repeat (6) @(negedge clk); sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        bus_read(2'd1, v); check_eq("R7", "no completion while deselected", int'(v[7]), 0);

        begin
            item_t it;
            bus_write(2'd2, 8'hC3);
            it.slv = 1'b1; it.rx = 8'h5A; it.line = 8'hC3; it.tag = "s1";
            sb_q.push_back(it); n_items++;
            fork
                s_drive(8'h5A, 8);
                begin
                    repeat (6) @(negedge clk);
                    check_eq("R2", "slave selected enables", int'({sck_oe, mosi_oe, miso_oe}), 3'b001);
                end
            join
            wait (mon_done == n_items);
        end

        // Abort mid-byte, then a clean byte
        bus_write(2'd2, 8'hF0);
        s_drive(8'hFF, 3);
        bus_read(2'd1, v); check_eq("R7", "aborted byte no flag", int'(v[7]), 0);
        begin
            item_t it;
            bus_write(2'd2, 8'h69);
            it.slv = 1'b1; it.rx = 8'h24; it.line = 8'h69; it.tag = "s2";
            sb_q.push_back(it); n_items++;
            s_drive(8'h24, 8);
            wait (mon_done == n_items);
        end

        bus_write(2'd0, 8'h00);
        check_eq("R2", "disabled again", int'({sck_oe, mosi_oe, miso_oe}), 0);
        finish_run();
    end
endmodule